// File: doc/BRIEF.md
# Window Watchdog Timer with Early-Warning Interrupt

This block is a down-counting supervisory timer. Once firmware enables it, the counter steps down by one on each pulse of an external prescaled tick. Firmware must reload the counter often enough to keep it from running out. It must also not reload too soon: a reload is only accepted while the count is at or below a programmable window level. A reload that comes too early asserts the reset output, and so does letting the counter run out.

Before the count runs out, the block latches an early-warning flag that can drive an interrupt line. Firmware can use it to save state before the reset arrives. The enable cannot be withdrawn by software. After any fault the reset output stays asserted until the block itself is reset, so a crashed program cannot undo it.

Software reaches the block through a single-cycle write port with three registers. The control register at address 0 holds the enable in bit 7 and the reload value in bits 6..0. The window register at address 1 holds the window level in bits 6..0. The interrupt register at address 2 holds the interrupt enable in bit 0, and writing a 1 to bit 1 clears the flag.

Top module: `wwdog_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rst_o` and `irq_o` are 0, the watchdog is disabled, the counter is 0x7F and the window level is 0x7F.
- R2: While enabled, each cycle with `tick` high and no control write decrements the counter by one. A tick taken while the counter is at or below 0x40 (the expiry step from 0x40 to 0x3F) asserts `rst_o` on the following cycle.
- R3: A write to address 0 loads bits 6..0 of `wr_data` into the counter, which restarts the countdown from that value.
- R4: A write to address 0 while enabled and while the counter is strictly above the window level (address 1, bits 6..0) asserts `rst_o` on the next cycle. A reload at a counter equal to the window level is accepted.
- R5: If a control write loads a value below 0x40, `rst_o` stays 0 until the next tick. That tick asserts `rst_o`.
- R6: A tick that moves the counter from 0x41 to 0x40 sets the warning flag. The flag holds until a write to address 2 with bit 1 set. If a set and a clear fall in the same cycle, the set wins. `irq_o` is the flag ANDed with the interrupt enable (address 2, bit 0).
- R7: Writing bit 7 of address 0 as 1 enables the watchdog. A later control write with bit 7 at 0 leaves it enabled. Only `rst` disables it.
- R8: While disabled, ticks leave the counter unchanged and no control write is ever treated as early.
- R9: Once asserted, `rst_o` stays high until `rst`.
- R10: In a cycle with both a control write and a tick, the written value is loaded and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 window, 2 interrupt) |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Prescaled count pulse, one cycle wide |
| irq_o | output | 1 | Early-warning interrupt |
| rst_o | output | 1 | Watchdog reset request, held until `rst` |

## Verification
The bench places reloads exactly at the window level and one count above it. A design that used the wrong comparison there would either punish a legal reload or let an early one pass. It makes a control write and a tick land in the same cycle, which catches a design that decrements after loading and so shortens the countdown by one. It issues a clear and a warning set together, since losing that warning would leave firmware no notice before the reset. Finally, it writes the enable bit back to 0 and checks that expiry still arrives, and it runs long streams of ticks with the watchdog disabled to show that a disabled counter neither counts nor faults.

// File: rtl/wwdog_pkg.sv
package wwdog_pkg;

    localparam int CNT_W  = 7;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [CNT_W-1:0] EXPIRE_LVL = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] WARN_FROM  = EXPIRE_LVL + CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP    = {CNT_W{1'b1}};

    localparam int EN_BIT    = DATA_W - 1;
    localparam int IE_BIT    = 0;
    localparam int CLR_BIT   = 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_WIN  = 2'd1,
        SEL_IRQ  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic             reload;
        logic             set_en;
        logic [CNT_W-1:0] value;
        logic             win_wr;
        logic [CNT_W-1:0] win;
        logic             irq_wr;
        logic             irq_en;
        logic             irq_clr;
    } wr_cmd_t;

    typedef struct packed {
        logic early;
        logic expire;
        logic warn;
    } evt_t;

    function automatic wr_cmd_t decode_write(
        input logic              we,
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] data
    );
        wr_cmd_t c;
        c         = '0;
        c.value   = data[CNT_W-1:0];
        c.win     = data[CNT_W-1:0];
        c.set_en  = data[EN_BIT];
        c.irq_en  = data[IE_BIT];
        c.reload  = we && (addr == SEL_CTRL);
        c.win_wr  = we && (addr == SEL_WIN);
        c.irq_wr  = we && (addr == SEL_IRQ);
        c.irq_clr = c.irq_wr && data[CLR_BIT];
        return c;
    endfunction

endpackage

// File: rtl/wwdog_regs.sv
module wwdog_regs
    import wwdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] WIN_RST = CNT_TOP
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    output logic             en_q,
    output logic [CNT_W-1:0] win_q,
    output logic             irq_en_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            win_q    <= WIN_RST;
            irq_en_q <= 1'b0;
        end else begin
            if (cmd.reload && cmd.set_en) en_q <= 1'b1;
            if (cmd.win_wr)               win_q <= cmd.win;
            if (cmd.irq_wr)               irq_en_q <= cmd.irq_en;
        end
    end

endmodule

// File: rtl/wwdog_counter.sv
module wwdog_counter
    import wwdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] CNT_RST = CNT_TOP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_q,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] value,
    input  logic [CNT_W-1:0] win_q,
    output logic [CNT_W-1:0] cnt_q,
    output evt_t             evt
);

    logic step;

    always_comb begin
        step       = tick && en_q && !reload;
        evt.early  = reload && en_q && (cnt_q > win_q);
        evt.expire = step && (cnt_q <= EXPIRE_LVL);
        evt.warn   = step && (cnt_q == WARN_FROM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_RST;
        end else if (reload) begin
            cnt_q <= value;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wwdog_events.sv
module wwdog_events
    import wwdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  logic irq_clr,
    input  logic irq_en_q,
    output logic flag_q,
    output logic fault_q,
    output logic irq_o,
    output logic rst_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= fault_q || evt.early || evt.expire;
            flag_q  <= evt.warn || (flag_q && !irq_clr);
        end
    end

    assign irq_o = flag_q && irq_en_q;
    assign rst_o = fault_q;

endmodule

// File: rtl/wwdog_top.sv
module wwdog_top
    import wwdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic              irq_o,
    output logic              rst_o
);

    wr_cmd_t          cmd;
    evt_t             evt;
    logic             en_q;
    logic             irq_en_q;
    logic             flag_q;
    logic             fault_q;
    logic             ctrl_wr;
    logic [CNT_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cmd     = decode_write(wr_en, wr_addr, wr_data);
        ctrl_wr = cmd.reload;
    end

    wwdog_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .en_q     (en_q),
        .win_q    (win_q),
        .irq_en_q (irq_en_q)
    );

    wwdog_counter i_counter (
        .clk    (clk),
        .rst    (rst),
        .en_q   (en_q),
        .tick   (tick),
        .reload (cmd.reload),
        .value  (cmd.value),
        .win_q  (win_q),
        .cnt_q  (cnt_q),
        .evt    (evt)
    );

    wwdog_events i_events (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .irq_clr  (cmd.irq_clr),
        .irq_en_q (irq_en_q),
        .flag_q   (flag_q),
        .fault_q  (fault_q),
        .irq_o    (irq_o),
        .rst_o    (rst_o)
    );

endmodule

// File: rtl/wwdog_checker.sv
module wwdog_checker
    import wwdog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [DATA_W-1:0] wr_data,
    input logic              ctrl_wr,
    input logic              irq_clr,
    input logic              en_q,
    input logic              flag_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  win_q,
    input logic              rst_o
);

    // R9
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rst_o |=> rst_o);

    // R7
    en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        en_q |=> en_q);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !ctrl_wr) |=> $stable(cnt_q));

    // R2
    expiry_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && tick && !ctrl_wr && cnt_q == EXPIRE_LVL) |=> rst_o);

    // R4
    early_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && ctrl_wr && cnt_q > win_q) |=> rst_o);

    // R3
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !irq_clr) |=> flag_q);

endmodule

bind wwdog_top wwdog_checker i_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_data (wr_data),
    .ctrl_wr (ctrl_wr),
    .irq_clr (cmd.irq_clr),
    .en_q    (en_q),
    .flag_q  (flag_q),
    .cnt_q   (cnt_q),
    .win_q   (win_q),
    .rst_o   (rst_o)
);

// File: tb/test_wwdog_top.sv
module test_wwdog_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0;
    logic       irq_o;
    logic       rst_o;

    int checks = 0;
    int failures = 0;
    int cyc_count = 0;

    // bench model state
    logic       m_en, m_ie, m_flag, m_rst;
    logic [6:0] m_cnt, m_win;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wwdog_top i_wwdog_top (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .irq_o   (irq_o),
        .rst_o   (rst_o)
    );

    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > WATCHDOG_CYCLES) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic model_irq();
        return m_flag && m_ie;
    endfunction

    task automatic model_reset();
        m_en = 0; m_ie = 0; m_flag = 0; m_rst = 0;
        m_cnt = 7'h7F; m_win = 7'h7F;
    endtask

    task automatic model_step(input logic we, input logic [1:0] a,
                              input logic [7:0] d, input logic t);
        logic ctrl, step, early, expire, warn, clr;
        ctrl   = we && a == 2'd0;
        step   = t && m_en && !ctrl;
        early  = ctrl && m_en && (m_cnt > m_win);
        expire = step && (m_cnt <= 7'h40);
        warn   = step && (m_cnt == 7'h41);
        clr    = we && a == 2'd2 && d[1];
        m_rst  = m_rst || early || expire;
        m_flag = warn || (m_flag && !clr);
        if (we && a == 2'd2) m_ie = d[0];
        if (we && a == 2'd1) m_win = d[6:0];
        if (ctrl && d[7]) m_en = 1'b1;
        if (ctrl) m_cnt = d[6:0];
        else if (step) m_cnt = m_cnt - 7'd1;
    endtask

    task automatic cyc(input logic we, input logic [1:0] a,
                       input logic [7:0] d, input logic t);
        wr_en = we; wr_addr = a; wr_data = d; tick = t;
        @(posedge clk);
        model_step(we, a, d, t);
        #1;
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_en = 1'b0; tick = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        model_reset();
        do_reset();

        // R1 reset state
        chk(rst_o, 1'b0, "R1 rst_o after reset");
        chk(irq_o, 1'b0, "R1 irq_o after reset");

        // R8 disabled: ticks do not count, reloads never early
        ticks(150);
        chk(rst_o, 1'b0, "R8 no expiry while disabled");
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h7F);
        idle(1);
        chk(rst_o, 1'b0, "R8 reload above window while disabled");

        // R2 / R6 expiry and warning
        do_reset();
        wr(2'd2, 8'h01);
        wr(2'd0, 8'hC5);
        ticks(3);
        chk(irq_o, 1'b0, "R6 no warning at 0x42");
        ticks(1);
        chk(irq_o, 1'b0, "R6 no warning at 0x41");
        ticks(1);
        chk(irq_o, 1'b1, "R6 warning at 0x40");
        chk(rst_o, 1'b0, "R2 no reset at 0x40");
        ticks(1);
        chk(rst_o, 1'b1, "R2 reset on expiry tick");
        // R9 sticky reset output
        wr(2'd0, 8'hC5);
        idle(5);
        chk(rst_o, 1'b1, "R9 rst_o held");

        // R3 reload restarts the countdown
        do_reset();
        wr(2'd0, 8'hC5);
        ticks(4);
        wr(2'd0, 8'hC5);
        ticks(5);
        chk(rst_o, 1'b0, "R3 reload postponed expiry");
        ticks(1);
        chk(rst_o, 1'b1, "R3 expiry after full restarted count");

        // R4 early reload
        do_reset();
        wr(2'd1, 8'h50);
        wr(2'd0, 8'hE0);
        chk(rst_o, 1'b0, "R4 first enable not early");
        wr(2'd0, 8'hE0);
        chk(rst_o, 1'b1, "R4 reload above window");
        do_reset();
        wr(2'd1, 8'h50);
        wr(2'd0, 8'hE0);
        ticks(15);
        wr(2'd0, 8'hE0);
        chk(rst_o, 1'b1, "R4 reload at window+1");
        do_reset();
        wr(2'd1, 8'h50);
        wr(2'd0, 8'hE0);
        ticks(16);
        wr(2'd0, 8'hE0);
        chk(rst_o, 1'b0, "R4 reload at window accepted");

        // R5 reload below expiry level
        do_reset();
        wr(2'd0, 8'hBF);
        idle(3);
        chk(rst_o, 1'b0, "R5 no reset before tick");
        ticks(1);
        chk(rst_o, 1'b1, "R5 reset on next tick");

        // R6 latched flag, mask, clear, set beats clear
        do_reset();
        wr(2'd0, 8'hC2);
        ticks(2);
        chk(irq_o, 1'b0, "R6 masked flag");
        wr(2'd2, 8'h01);
        chk(irq_o, 1'b1, "R6 flag latched then unmasked");
        wr(2'd2, 8'h03);
        chk(irq_o, 1'b0, "R6 flag cleared");
        wr(2'd0, 8'hC1);
        cyc(1'b1, 2'd2, 8'h03, 1'b1);
        chk(irq_o, 1'b1, "R6 set wins over clear");

        // R7 enable sticky
        do_reset();
        wr(2'd0, 8'hC5);
        wr(2'd0, 8'h45);
        ticks(6);
        chk(rst_o, 1'b1, "R7 still enabled after bit7=0 write");

        // R10 write beats tick
        do_reset();
        wr(2'd0, 8'hC5);
        ticks(4);
        cyc(1'b1, 2'd0, 8'hC5, 1'b1);
        ticks(5);
        chk(rst_o, 1'b0, "R10 tick dropped on write cycle");
        ticks(1);
        chk(rst_o, 1'b1, "R10 expiry after full count");

        // random stream against the bench model
        begin
            int seed;
            seed = $urandom(32'h1234_5678);
            do_reset();
            for (int i = 0; i < 6000; i++) begin
                logic       we, t;
                logic [1:0] a;
                logic [7:0] d;
                we = ($urandom_range(0, 15) == 0);
                t  = ($urandom_range(0, 1) == 1);
                a  = 2'($urandom_range(0, 3));
                d  = 8'($urandom);
                if (a == 2'd0) d[6] = ($urandom_range(0, 7) != 0);
                if (a == 2'd1) d[6] = 1'b1;
                cyc(we, a, d, t);
                chk(rst_o, m_rst, "R2/R4 random rst_o");
                chk(irq_o, model_irq(), "R6 random irq_o");
                if (m_rst && $urandom_range(0, 3) == 0) do_reset();
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule